// File: doc/BRIEF.md
# Posted-Write Synchronization Barrier Unit

This block rules on read cycles that must not finish while write data that has been posted and acknowledged is still buffered inside the device. Each clock cycle a requester may present one cycle to it. A cycle is described by its source, address, command, a flag that marks an access to internal registers, and a flag that marks a locked read. One cycle later the block answers with one of three decisions. DONE means the cycle may finish now. RETRY means the target bus must terminate it with a retry. HOLD means the cycle stays pending and the requester must present it again on the next cycle.

There are two target-side ports and one host-CPU port. On a target port, configuration reads are barrier cycles, and so are locked reads on port 0 only. On the host port, I/O reads and configuration reads are barrier cycles, and they are held rather than retried. The block tracks one barrier owner, identified by its source, address and command. While a lock is held, the barrier extends over the whole lock, so register and configuration traffic from other requesters is turned away.

Top module: `pwb_barrier`

## Requirements
- R1: A cycle that is neither a barrier cycle nor a register access (`req_reg_i`=0) gets DONE (code 1), whatever the state of `pend_i`. Commands are memory read 4'h6, memory write 4'h7, I/O read 4'h2 and configuration read 4'hA. Commands with bit 0 clear are reads.
- R2: A barrier cycle gets DONE when no barrier owner is outstanding and `pend_i` is 0.
- R3: A target-side barrier cycle that is the owner, or that finds no owner, gets HOLD (code 3) while `pend_i` is 1 and `tick_i` is 0. It gets RETRY (code 2) while `pend_i` is 1 and `tick_i` is 1. It gets DONE once `pend_i` is 0.
- R4: A target-side barrier cycle whose source, address or command differs from the outstanding owner gets RETRY. A cycle that repeats the owner's source, address and command is treated as the owner.
- R5: The owner is released when its cycle gets DONE outside a lock, so that a different barrier cycle is accepted afterwards.
- R6: A locked read (`req_lock_i`=1, read command) from source 0 (target port 0) takes ownership and waits for drain like R3. Ownership stays until the lock ends. During the lock, every configuration read and every register access from other cycles is turned away. Further locked reads from source 0 complete once drained.
- R7: A locked read from source 1 (target port 1), and an I/O read from either target port, is not a barrier cycle.
- R8: A host-side barrier cycle (source 2) never gets RETRY. Where a target cycle would be retried, or while posted data remains, it gets HOLD. It gets DONE once drained and not blocked.
- R9: Every cycle with `req_vld_i` high gets exactly one response, with `rsp_vld_o` high on the following clock cycle. There is no response otherwise.
- R10: While `rst` is high, `rsp_vld_o` is 0.
- R11: A `lock_end_i` pulse during a lock releases ownership, and barrier cycles are accepted again from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | 1 | Posted write data is still buffered |
| tick_i | input | 1 | Retry period has elapsed for the waiting target cycle |
| lock_end_i | input | 1 | The current lock is over |
| req_vld_i | input | 1 | A cycle is presented this clock |
| req_src_i | input | 2 | 0 target port 0, 1 target port 1, 2 host CPU |
| req_addr_i | input | AW | Cycle address |
| req_cmd_i | input | 4 | Cycle command |
| req_reg_i | input | 1 | Cycle addresses internal registers |
| req_lock_i | input | 1 | Cycle is a locked read |
| rsp_vld_o | output | 1 | Decision valid |
| rsp_code_o | output | 2 | 1 DONE, 2 RETRY, 3 HOLD |

## Verification
Plain memory traffic with data pending shows that gating applies only to barrier cycles. Barrier reads with data pending and the retry tick low, and then high, separate HOLD from RETRY. A second barrier at a new address, presented against an outstanding owner and then presented again after that owner has drained, shows that one owner is tracked and that it is released. A lock sequence mixes configuration, register, plain and locked cycles from every source, which separates the port-0 lock barrier from port-1 locked reads. Host reads with the tick high show that the host is only ever held.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int CMD_W = 4;
  localparam logic [CMD_W-1:0] CMD_IO_RD  = 4'h2;
  localparam logic [CMD_W-1:0] CMD_MEM_RD = 4'h6;
  localparam logic [CMD_W-1:0] CMD_MEM_WR = 4'h7;
  localparam logic [CMD_W-1:0] CMD_CFG_RD = 4'hA;

  typedef enum logic [1:0] {SRC_T0 = 2'd0, SRC_T1 = 2'd1, SRC_HOST = 2'd2} src_e;
  typedef enum logic [1:0] {RSP_NONE = 2'd0, RSP_DONE = 2'd1, RSP_RETRY = 2'd2, RSP_HOLD = 2'd3} rsp_e;
endpackage

// File: rtl/pwb_classify.sv
module pwb_classify
  import pwb_pkg::*;
(
  input  logic [1:0]       src_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             lock_i,
  output logic             is_bar_o,
  output logic             lk_bar_o,
  output logic             is_host_o
);
  logic is_read;
  always_comb begin
    is_read   = ~cmd_i[0];
    is_host_o = (src_i == SRC_HOST);
    lk_bar_o  = lock_i && is_read && (src_i == SRC_T0);
    is_bar_o  = (cmd_i == CMD_CFG_RD) || lk_bar_o || (is_host_o && cmd_i == CMD_IO_RD);
  end
endmodule

// File: rtl/pwb_owner.sv
module pwb_owner
  import pwb_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             claim_i,
  input  logic             claim_lk_i,
  input  logic             release_i,
  input  logic             lock_end_i,
  input  logic [1:0]       src_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [CMD_W-1:0] cmd_i,
  output logic             own_vld_o,
  output logic             own_lk_o,
  output logic             match_o
);
  logic [1:0]       own_src;
  logic [AW-1:0]    own_addr;
  logic [CMD_W-1:0] own_cmd;

  always_ff @(posedge clk) begin
    if (rst) begin
      own_vld_o <= 1'b0;
      own_lk_o  <= 1'b0;
      own_src   <= '0;
      own_addr  <= '0;
      own_cmd   <= '0;
    end else if (lock_end_i && own_lk_o) begin
      own_vld_o <= 1'b0;
      own_lk_o  <= 1'b0;
    end else if (release_i) begin
      own_vld_o <= 1'b0;
    end else if (claim_i) begin
      own_vld_o <= 1'b1;
      own_lk_o  <= claim_lk_i;
      own_src   <= src_i;
      own_addr  <= addr_i;
      own_cmd   <= cmd_i;
    end
  end

  assign match_o = own_vld_o && (own_src == src_i) && (own_addr == addr_i) && (own_cmd == cmd_i);

  a_r6_lock_owned: assert property (@(posedge clk) disable iff (rst) own_lk_o |-> own_vld_o);
  a_r11_unlock: assert property (@(posedge clk) disable iff (rst)
    (lock_end_i && own_lk_o) |=> (!own_lk_o && !own_vld_o));
endmodule

// File: rtl/pwb_decide.sv
module pwb_decide
  import pwb_pkg::*;
(
  input  logic       vld_i,
  input  logic       pend_i,
  input  logic       tick_i,
  input  logic       reg_i,
  input  logic       is_bar_i,
  input  logic       lk_bar_i,
  input  logic       is_host_i,
  input  logic       holder_i,
  input  logic       own_vld_i,
  input  logic       own_lk_i,
  input  logic       match_i,
  output logic [1:0] code_o,
  output logic       claim_o,
  output logic       release_o
);
  logic [1:0] reject;
  logic [1:0] wait_code;
  always_comb begin
    reject    = is_host_i ? RSP_HOLD : RSP_RETRY;
    wait_code = (is_host_i || !tick_i) ? RSP_HOLD : RSP_RETRY;
    code_o    = RSP_DONE;
    claim_o   = 1'b0;
    release_o = 1'b0;
    if (!is_bar_i && !reg_i) begin
      code_o = RSP_DONE;
    end else if (own_lk_i && !holder_i) begin
      code_o = reject;
    end else if (!is_bar_i && !holder_i) begin
      code_o = RSP_DONE;
    end else if (own_vld_i && !match_i && !holder_i) begin
      code_o = reject;
    end else begin
      claim_o = vld_i && !own_vld_i && (pend_i || lk_bar_i);
      if (pend_i) begin
        code_o = wait_code;
      end else begin
        code_o    = RSP_DONE;
        release_o = vld_i && own_vld_i && !own_lk_i;
      end
    end
  end
endmodule

// File: rtl/pwb_barrier.sv
module pwb_barrier
  import pwb_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pend_i,
  input  logic             tick_i,
  input  logic             lock_end_i,
  input  logic             req_vld_i,
  input  logic [1:0]       req_src_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [CMD_W-1:0] req_cmd_i,
  input  logic             req_reg_i,
  input  logic             req_lock_i,
  output logic             rsp_vld_o,
  output logic [1:0]       rsp_code_o
);
  logic is_bar, lk_bar, is_host;
  logic own_vld, own_lk, match, holder;
  logic claim, release_own;
  logic [1:0] code;

  pwb_classify u_cls (
    .src_i(req_src_i), .cmd_i(req_cmd_i), .lock_i(req_lock_i),
    .is_bar_o(is_bar), .lk_bar_o(lk_bar), .is_host_o(is_host)
  );

  assign holder = own_lk && lk_bar;

  pwb_decide u_dec (
    .vld_i(req_vld_i), .pend_i(pend_i), .tick_i(tick_i), .reg_i(req_reg_i),
    .is_bar_i(is_bar), .lk_bar_i(lk_bar), .is_host_i(is_host), .holder_i(holder),
    .own_vld_i(own_vld), .own_lk_i(own_lk), .match_i(match),
    .code_o(code), .claim_o(claim), .release_o(release_own)
  );

  pwb_owner #(.AW(AW)) u_own (
    .clk(clk), .rst(rst), .claim_i(claim), .claim_lk_i(lk_bar),
    .release_i(release_own), .lock_end_i(lock_end_i),
    .src_i(req_src_i), .addr_i(req_addr_i), .cmd_i(req_cmd_i),
    .own_vld_o(own_vld), .own_lk_o(own_lk), .match_o(match)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld_o  <= 1'b0;
      rsp_code_o <= RSP_NONE;
    end else begin
      rsp_vld_o  <= req_vld_i;
      rsp_code_o <= req_vld_i ? code : RSP_NONE;
    end
  end

  a_r9_resp_follows: assert property (@(posedge clk) disable iff (rst) req_vld_i |=> rsp_vld_o);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst) !req_vld_i |=> !rsp_vld_o);
  a_r8_host_no_retry: assert property (@(posedge clk) disable iff (rst)
    (req_vld_i && req_src_i == SRC_HOST) |=> rsp_code_o != RSP_RETRY);
  a_r1_write_pass: assert property (@(posedge clk) disable iff (rst)
    (req_vld_i && !req_reg_i && req_cmd_i == CMD_MEM_WR) |=> rsp_code_o == RSP_DONE);
  a_r2_free_done: assert property (@(posedge clk) disable iff (rst)
    (req_vld_i && !pend_i && !own_vld) |=> rsp_code_o == RSP_DONE);
endmodule

// File: tb/tb_pwb_barrier.sv
module tb_pwb_barrier;
  localparam int AW = 32;
  localparam logic [1:0] DN = 2'd1, RT = 2'd2, HD = 2'd3;
  localparam logic [3:0] IO = 4'h2, MR = 4'h6, MW = 4'h7, CF = 4'hA;

  logic clk = 1'b0, rst = 1'b1;
  logic pend_i = 0, tick_i = 0, lock_end_i = 0, req_vld_i = 0, req_reg_i = 0, req_lock_i = 0;
  logic [1:0] req_src_i = 0;
  logic [AW-1:0] req_addr_i = 0;
  logic [3:0] req_cmd_i = 0;
  logic rsp_vld_o;
  logic [1:0] rsp_code_o;
  int total = 0, bad = 0;
  bit finished = 0;
  logic [1:0] qc[$];
  string qt[$];

  always #4 clk = ~clk;

  pwb_barrier #(.AW(AW)) dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic req(input logic [1:0] s, input logic [AW-1:0] a, input logic [3:0] c,
                     input logic rg, input logic lk, input logic p, input logic tk,
                     input logic [1:0] exp, input string tag);
    @(negedge clk);
    req_vld_i = 1; req_src_i = s; req_addr_i = a; req_cmd_i = c;
    req_reg_i = rg; req_lock_i = lk; pend_i = p; tick_i = tk; lock_end_i = 0;
    qc.push_back(exp); qt.push_back(tag);
  endtask

  task automatic idle(input logic le);
    @(negedge clk);
    req_vld_i = 0; req_reg_i = 0; req_lock_i = 0; tick_i = 0; lock_end_i = le;
  endtask

  always @(negedge clk) begin
    if (!rst && rsp_vld_o) begin
      if (qc.size() == 0) chk(0, "R9 unexpected response", 1, 0);
      else begin
        logic [1:0] e;
        string t;
        e = qc.pop_front();
        t = qt.pop_front();
        chk(rsp_code_o == e, t, rsp_code_o, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      chk(0, "R9 watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    req_vld_i = 1; req_cmd_i = CF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rsp_vld_o == 0, "R10 reset quiet", rsp_vld_o, 0);
    rst = 0; req_vld_i = 0;
    idle(0);
    // R1 / R7 pass-through with data pending
    req(0, 32'h100, MR, 0, 0, 1, 0, DN, "R1 mem read t0");
    req(2, 32'h104, MW, 0, 0, 1, 1, DN, "R1 host mem write");
    req(1, 32'h108, MR, 1, 0, 1, 0, DN, "R1 register read no lock");
    req(0, 32'h10C, IO, 0, 0, 1, 0, DN, "R7 target io read");
    req(1, 32'h110, MR, 0, 1, 1, 0, DN, "R7 port1 locked read");
    // R2 drained barriers
    req(0, 32'h10, CF, 0, 0, 0, 0, DN, "R2 cfg read drained");
    req(2, 32'h40, IO, 0, 0, 0, 0, DN, "R2 host io drained");
    // R3/R4/R5 ownership
    req(0, 32'h20, CF, 0, 0, 1, 0, HD, "R3 cfg pending hold");
    req(0, 32'h20, CF, 0, 0, 1, 1, RT, "R3 cfg retry on tick");
    req(1, 32'h30, CF, 0, 0, 1, 0, RT, "R4 other barrier retried");
    req(2, 32'h44, CF, 0, 0, 0, 0, HD, "R8 host blocked held");
    req(0, 32'h20, CF, 0, 0, 0, 0, DN, "R4 same cycle completes");
    req(1, 32'h30, CF, 0, 0, 1, 0, HD, "R5 released new owner");
    req(1, 32'h30, CF, 0, 0, 0, 0, DN, "R5 new owner done");
    // R8 host hold
    req(2, 32'h48, CF, 0, 0, 1, 1, HD, "R8 host hold on tick");
    req(2, 32'h48, CF, 0, 0, 1, 0, HD, "R8 host hold again");
    req(2, 32'h48, CF, 0, 0, 0, 0, DN, "R8 host done drained");
    // R6 lock
    req(0, 32'h50, MR, 0, 1, 1, 0, HD, "R6 locked read waits");
    req(0, 32'h50, MR, 0, 1, 1, 1, RT, "R6 locked read retry tick");
    req(0, 32'h50, MR, 0, 1, 0, 0, DN, "R6 locked read drained");
    req(1, 32'h60, CF, 0, 0, 0, 0, RT, "R6 cfg during lock");
    req(1, 32'h64, MR, 1, 0, 0, 0, RT, "R6 register during lock");
    req(1, 32'h68, MR, 0, 0, 1, 0, DN, "R1 plain read during lock");
    req(1, 32'h6C, MR, 0, 1, 1, 0, DN, "R7 port1 locked in lock");
    req(2, 32'h70, CF, 0, 0, 0, 0, HD, "R6 host cfg during lock");
    req(0, 32'h54, MR, 0, 1, 0, 0, DN, "R6 lock holder continues");
    idle(1);
    req(1, 32'h60, CF, 0, 0, 0, 0, DN, "R11 cfg after unlock");
    idle(0);
    repeat (3) idle(0);
    chk(qc.size() == 0, "R9 all responses seen", qc.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule